// File: doc/BRIEF.md
# Register Rename Map with Checkpoint Recovery

This block keeps, for each architectural register, the reorder-buffer slot of the newest in-flight instruction that will write it. Each row holds a valid flag and that slot number. Two source lookups per cycle return the flag and the slot. A set flag means the named reorder-buffer entry holds the value now or will hold it later. A clear flag means no in-flight instruction writes the register, so the value sits in the architectural register file. Renaming a destination points its row at the slot just allocated at the reorder-buffer tail. A retiring entry clears only the rows that still name it.

Two recovery paths are provided. A flush drops every mapping. It is used once a faulting instruction has reached retirement. Faster recovery uses a small pool of snapshot slots. A snapshot of the whole map is saved at each speculation point, and the saved map is reloaded when a misprediction is found. Snapshot slots are handed out in circular order. Reloading one slot releases it and every slot taken after it. Releasing the oldest slot retires a resolved speculation point. When no slot is free, a snapshot request stalls rename.

Top module: `rename_map`

## Requirements
- R1: After reset, every lookup reports invalid, no snapshot slot is held, the next-slot output `ckpt_slot` is 0 and `ckpt_stall` is low.
- R2: In every cycle, `srcN_valid` and `srcN_rob` give the valid flag and the slot of row `srcN_reg` for both lookup ports. The outputs are combinational from the stored map.
- R3: A lookup in the same cycle as a destination write to the same register returns the mapping as it stood before that write.
- R4: An accepted rename with `ren_en` high sets row `ren_dst` valid with slot `ren_rob`. The new mapping is visible from the next cycle.
- R5: With `commit_en` high, a row is cleared only if it is valid and its slot equals `commit_rob`. A rename to that row in the same cycle keeps the new mapping.
- R6: An accepted snapshot request saves the map as it stands after the same cycle's rename and commit, into slot `ckpt_slot`. `ckpt_slot` then advances by one, modulo the slot count.
- R7: A commit also clears every saved mapping whose slot equals `commit_rob`, in every held snapshot except one being written in that cycle.
- R8: When `ckpt_req` is high and all slots are held, `ckpt_stall` is high in that cycle, and both the rename write and the snapshot are dropped.
- R9: `restore_en` loads the map from snapshot `restore_slot` and frees that slot and all slots taken after it, so `ckpt_slot` becomes `restore_slot`. It overrides rename, commit, snapshot and release in that cycle.
- R10: `flush` clears every valid flag and frees every slot. It overrides every other request in that cycle.
- R11: `ckpt_release` frees the oldest held slot. It has no effect when no slot is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src0_reg | input | 4 | Architectural register for lookup port 0 |
| src1_reg | input | 4 | Architectural register for lookup port 1 |
| src0_valid | output | 1 | Port 0 mapping valid |
| src0_rob | output | 5 | Port 0 reorder-buffer slot |
| src1_valid | output | 1 | Port 1 mapping valid |
| src1_rob | output | 5 | Port 1 reorder-buffer slot |
| ren_en | input | 1 | Destination rename request |
| ren_dst | input | 4 | Destination architectural register |
| ren_rob | input | 5 | Newly allocated reorder-buffer slot |
| commit_en | input | 1 | An entry retires this cycle |
| commit_rob | input | 5 | Slot of the retiring entry |
| ckpt_req | input | 1 | Save a snapshot this cycle |
| ckpt_slot | output | 2 | Slot the next snapshot will take |
| ckpt_stall | output | 1 | Snapshot request refused, all slots held |
| ckpt_release | input | 1 | Free the oldest held snapshot |
| restore_en | input | 1 | Reload the map from a held snapshot |
| restore_slot | input | 2 | Snapshot slot to reload |
| flush | input | 1 | Clear all mappings and free all slots |

## Verification
The lookup results, `ckpt_stall` and `ckpt_slot` depend on the current inputs and the stored state with no register in between. The bench drives inputs just after a falling edge and samples these outputs one nanosecond later, in the same cycle. Rename, commit, snapshot, restore, flush and release change state at the next rising edge. Their effects first show up in the lookups of the following cycle, and the reference model advances at that same edge. Directed sequences cover the same-cycle bypass, exact-match commit, snapshot capture and scrubbing, stall on a full pool, and rollback. Seeded random traffic then exercises every mix of requests against the model.

// File: rtl/rn_pkg.sv
package rn_pkg;
   typedef enum logic [1:0] {
      TBL_NORMAL  = 2'd0,
      TBL_FLUSH   = 2'd1,
      TBL_RESTORE = 2'd2
   } tbl_mode_e;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table
   import rn_pkg::*;
#(
   parameter int NREG = 16,
   parameter int IW   = 5,
   localparam int AW  = $clog2(NREG)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  tbl_mode_e                 mode,
   input  logic                      wr_en,
   input  logic [AW-1:0]             wr_reg,
   input  logic [IW-1:0]             wr_idx,
   input  logic                      cm_en,
   input  logic [IW-1:0]             cm_idx,
   input  logic [NREG-1:0]           rs_v,
   input  logic [NREG-1:0][IW-1:0]   rs_i,
   output logic [NREG-1:0]           cur_v,
   output logic [NREG-1:0][IW-1:0]   cur_i,
   output logic [NREG-1:0]           upd_v,
   output logic [NREG-1:0][IW-1:0]   upd_i
);

   for (genvar r = 0; r < NREG; r++) begin : g_row
      logic hit_wr;
      logic hit_cm;

      assign hit_wr   = wr_en && (wr_reg == AW'(r));
      assign hit_cm   = cm_en && cur_v[r] && (cur_i[r] == cm_idx);
      // rename wins over a clearing commit on the same row
      assign upd_v[r] = hit_wr ? 1'b1 : (hit_cm ? 1'b0 : cur_v[r]);
      assign upd_i[r] = hit_wr ? wr_idx : cur_i[r];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cur_v[r] <= 1'b0;
            cur_i[r] <= '0;
         end else begin
            case (mode)
               TBL_FLUSH:   cur_v[r] <= 1'b0;
               TBL_RESTORE: begin
                  cur_v[r] <= rs_v[r];
                  cur_i[r] <= rs_i[r];
               end
               default: begin
                  cur_v[r] <= upd_v[r];
                  cur_i[r] <= upd_i[r];
               end
            endcase
         end
      end

      // R5: a commit naming another slot leaves a valid row valid
      a_r5_commit_exact_match: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == TBL_NORMAL && cm_en && cur_v[r] && cur_i[r] != cm_idx)
         |=> cur_v[r]);
   end

   a_r4_rename_installs: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TBL_NORMAL && wr_en)
      |=> (cur_v[$past(wr_reg)] && cur_i[$past(wr_reg)] == $past(wr_idx)));

   a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TBL_FLUSH) |=> (cur_v == '0));

endmodule

// File: rtl/rn_ckpt_ctrl.sv
module rn_ckpt_ctrl
   import rn_pkg::*;
#(
   parameter int NCK = 4,
   localparam int CW = $clog2(NCK)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  tbl_mode_e     mode,
   input  logic [CW-1:0] rst_slot,
   input  logic          take,
   input  logic          rel_req,
   output logic [CW-1:0] wr_ptr,
   output logic          full
);

   logic [CW-1:0] rd_ptr;
   logic [CW:0]   cnt;
   logic          rel_ok;

   assign rel_ok = rel_req && (cnt != '0);
   assign full   = (cnt == (CW+1)'(NCK));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         case (mode)
            TBL_FLUSH: begin
               cnt    <= '0;
               rd_ptr <= wr_ptr;
            end
            TBL_RESTORE: begin
               wr_ptr <= rst_slot;
               cnt    <= {1'b0, CW'(rst_slot - rd_ptr)};
            end
            default: begin
               if (take)   wr_ptr <= wr_ptr + 1'b1;
               if (rel_ok) rd_ptr <= rd_ptr + 1'b1;
               cnt <= cnt + (CW+1)'(take) - (CW+1)'(rel_ok);
            end
         endcase
      end
   end

   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= (CW+1)'(NCK));

   a_r8_take_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TBL_NORMAL && take) |-> !full);

   a_r9_restore_live_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TBL_RESTORE) |-> (cnt != '0));

   a_r11_release_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TBL_NORMAL && !take && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/rn_ckpt_store.sv
module rn_ckpt_store
   import rn_pkg::*;
#(
   parameter int NREG = 16,
   parameter int IW   = 5,
   parameter int NCK  = 4,
   localparam int CW  = $clog2(NCK)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  tbl_mode_e                 mode,
   input  logic                      take,
   input  logic [CW-1:0]             wr_slot,
   input  logic [NREG-1:0]           img_v,
   input  logic [NREG-1:0][IW-1:0]   img_i,
   input  logic                      cm_en,
   input  logic [IW-1:0]             cm_idx,
   input  logic [CW-1:0]             rd_slot,
   output logic [NREG-1:0]           out_v,
   output logic [NREG-1:0][IW-1:0]   out_i
);

   logic [NREG-1:0]         snap_v [NCK];
   logic [NREG-1:0][IW-1:0] snap_i [NCK];

   for (genvar s = 0; s < NCK; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            snap_v[s] <= '0;
            snap_i[s] <= '0;
         end else if (mode == TBL_NORMAL) begin
            if (take && wr_slot == CW'(s)) begin
               snap_v[s] <= img_v;
               snap_i[s] <= img_i;
            end else if (cm_en) begin
               for (int r = 0; r < NREG; r++) begin
                  if (snap_v[s][r] && snap_i[s][r] == cm_idx) snap_v[s][r] <= 1'b0;
               end
            end
         end
      end

      // R7: a saved row naming the retiring slot is gone next cycle
      a_r7_scrub_row0: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == TBL_NORMAL && cm_en && !(take && wr_slot == CW'(s))
          && snap_v[s][0] && snap_i[s][0] == cm_idx) |=> !snap_v[s][0]);
   end

   assign out_v = snap_v[rd_slot];
   assign out_i = snap_i[rd_slot];

endmodule

// File: rtl/rename_map.sv
module rename_map
   import rn_pkg::*;
#(
   parameter int NREG = 16,
   parameter int IW   = 5,
   parameter int NCK  = 4,
   localparam int AW  = $clog2(NREG),
   localparam int CW  = $clog2(NCK)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] src0_reg,
   input  logic [AW-1:0] src1_reg,
   output logic          src0_valid,
   output logic [IW-1:0] src0_rob,
   output logic          src1_valid,
   output logic [IW-1:0] src1_rob,
   input  logic          ren_en,
   input  logic [AW-1:0] ren_dst,
   input  logic [IW-1:0] ren_rob,
   input  logic          commit_en,
   input  logic [IW-1:0] commit_rob,
   input  logic          ckpt_req,
   output logic [CW-1:0] ckpt_slot,
   output logic          ckpt_stall,
   input  logic          ckpt_release,
   input  logic          restore_en,
   input  logic [CW-1:0] restore_slot,
   input  logic          flush
);

   if (NREG < 2 || (1 << AW) != NREG) begin : g_bad_nreg
      $error("rename_map: NREG must be a power of two of at least 2");
   end
   if (NCK < 2 || (1 << CW) != NCK) begin : g_bad_nck
      $error("rename_map: NCK must be a power of two of at least 2");
   end
   if (IW < 1) begin : g_bad_iw
      $error("rename_map: IW must be at least 1");
   end

   tbl_mode_e               mode;
   logic                    full;
   logic                    wr_ok;
   logic                    take;
   logic                    rel;
   logic [NREG-1:0]         tbl_v;
   logic [NREG-1:0][IW-1:0] tbl_i;
   logic [NREG-1:0]         nxt_v;
   logic [NREG-1:0][IW-1:0] nxt_i;
   logic [NREG-1:0]         snap_v;
   logic [NREG-1:0][IW-1:0] snap_i;

   always_comb begin
      if (flush)           mode = TBL_FLUSH;
      else if (restore_en) mode = TBL_RESTORE;
      else                 mode = TBL_NORMAL;
   end

   assign ckpt_stall = ckpt_req && full;
   assign wr_ok      = ren_en && !ckpt_stall;
   assign take       = ckpt_req && !full && (mode == TBL_NORMAL);
   assign rel        = ckpt_release && (mode == TBL_NORMAL);

   rn_map_table #(.NREG(NREG), .IW(IW)) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode   (mode),
      .wr_en  (wr_ok),
      .wr_reg (ren_dst),
      .wr_idx (ren_rob),
      .cm_en  (commit_en),
      .cm_idx (commit_rob),
      .rs_v   (snap_v),
      .rs_i   (snap_i),
      .cur_v  (tbl_v),
      .cur_i  (tbl_i),
      .upd_v  (nxt_v),
      .upd_i  (nxt_i)
   );

   rn_ckpt_ctrl #(.NCK(NCK)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .rst_slot (restore_slot),
      .take     (take),
      .rel_req  (rel),
      .wr_ptr   (ckpt_slot),
      .full     (full)
   );

   rn_ckpt_store #(.NREG(NREG), .IW(IW), .NCK(NCK)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .take    (take),
      .wr_slot (ckpt_slot),
      .img_v   (nxt_v),
      .img_i   (nxt_i),
      .cm_en   (commit_en),
      .cm_idx  (commit_rob),
      .rd_slot (restore_slot),
      .out_v   (snap_v),
      .out_i   (snap_i)
   );

   assign src0_valid = tbl_v[src0_reg];
   assign src0_rob   = tbl_i[src0_reg];
   assign src1_valid = tbl_v[src1_reg];
   assign src1_rob   = tbl_i[src1_reg];

   a_r9_restore_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TBL_RESTORE) |=> (tbl_v == $past(snap_v)));

   a_r9_restore_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TBL_RESTORE) |=> (ckpt_slot == $past(restore_slot)));

   a_r8_stall_drops_write: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TBL_NORMAL && ckpt_stall && !commit_en) |=> $stable(tbl_v));

endmodule

// File: tb/sim_rename_map.sv
`timescale 1ns/1ps
module sim_rename_map;
   localparam int NREG = 16;
   localparam int IW   = 5;
   localparam int NCK  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] src0_reg, src1_reg, ren_dst;
   logic       src0_valid, src1_valid, ckpt_stall;
   logic [4:0] src0_rob, src1_rob, ren_rob, commit_rob;
   logic       ren_en, commit_en, ckpt_req, ckpt_release, restore_en, flush;
   logic [1:0] ckpt_slot, restore_slot;

   int total = 0;
   int bad = 0;
   bit done = 0;

   bit mv [NREG];
   int mi [NREG];
   bit sv [NCK][NREG];
   int si [NCK][NREG];
   int rd = 0, wr = 0, cnt = 0;

   always #2.5 clk = ~clk;

   rename_map u0 (
      .clk(clk), .rst_n(rst_n),
      .src0_reg(src0_reg), .src1_reg(src1_reg),
      .src0_valid(src0_valid), .src0_rob(src0_rob),
      .src1_valid(src1_valid), .src1_rob(src1_rob),
      .ren_en(ren_en), .ren_dst(ren_dst), .ren_rob(ren_rob),
      .commit_en(commit_en), .commit_rob(commit_rob),
      .ckpt_req(ckpt_req), .ckpt_slot(ckpt_slot), .ckpt_stall(ckpt_stall),
      .ckpt_release(ckpt_release), .restore_en(restore_en),
      .restore_slot(restore_slot), .flush(flush)
   );

   task automatic chk(input string req, input string what, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, got, exp, $time);
      end
   endtask

   task automatic idle();
      ren_en = 0; ren_dst = 0; ren_rob = 0; commit_en = 0; commit_rob = 0;
      ckpt_req = 0; ckpt_release = 0; restore_en = 0; restore_slot = 0; flush = 0;
   endtask

   function automatic bit exp_stall();
      return ckpt_req && (cnt == NCK);
   endfunction

   // reference state update per R4..R11, applied at the rising edge
   task automatic model_step();
      bit nv [NREG];
      int ni [NREG];
      bit stl;
      stl = exp_stall();
      if (flush) begin
         for (int r = 0; r < NREG; r++) mv[r] = 0;
         cnt = 0; rd = wr;
      end else if (restore_en) begin
         for (int r = 0; r < NREG; r++) begin mv[r] = sv[restore_slot][r]; mi[r] = si[restore_slot][r]; end
         cnt = (int'(restore_slot) - rd) & (NCK-1);
         wr = restore_slot;
      end else begin
         bit tk, rl;
         for (int r = 0; r < NREG; r++) begin
            nv[r] = mv[r]; ni[r] = mi[r];
            if (ren_en && !stl && r == ren_dst) begin nv[r] = 1; ni[r] = ren_rob; end
            else if (commit_en && mv[r] && mi[r] == commit_rob) nv[r] = 0;
         end
         tk = ckpt_req && !stl;
         rl = ckpt_release && cnt != 0;
         for (int s = 0; s < NCK; s++) begin
            if (tk && s == wr) begin
               for (int r = 0; r < NREG; r++) begin sv[s][r] = nv[r]; si[s][r] = ni[r]; end
            end else if (commit_en) begin
               for (int r = 0; r < NREG; r++) if (sv[s][r] && si[s][r] == commit_rob) sv[s][r] = 0;
            end
         end
         if (tk) begin wr = (wr + 1) % NCK; cnt++; end
         if (rl) begin rd = (rd + 1) % NCK; cnt--; end
         for (int r = 0; r < NREG; r++) begin mv[r] = nv[r]; mi[r] = ni[r]; end
      end
   endtask

   // inputs set after a falling edge; outputs sampled 1 ns later
   task automatic go(input string req);
      #1;
      chk(req, "src0_valid", src0_valid, mv[src0_reg]);
      if (mv[src0_reg]) chk(req, "src0_rob", src0_rob, mi[src0_reg]);
      chk(req, "src1_valid", src1_valid, mv[src1_reg]);
      if (mv[src1_reg]) chk(req, "src1_rob", src1_rob, mi[src1_reg]);
      chk(req, "ckpt_stall", ckpt_stall, exp_stall());
      chk(req, "ckpt_slot", ckpt_slot, wr);
      @(posedge clk);
      model_step();
      @(negedge clk);
      idle();
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         bad++; total++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int r = 0; r < NREG; r++) begin mv[r] = 0; mi[r] = 0; end
      for (int s = 0; s < NCK; s++) for (int r = 0; r < NREG; r++) begin sv[s][r] = 0; si[s][r] = 0; end
      idle(); src0_reg = 0; src1_reg = 15;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      go("R1");
      src0_reg = 7; src1_reg = 3; go("R1");
      // R3: same-cycle lookup sees old mapping
      src0_reg = 3; ren_en = 1; ren_dst = 3; ren_rob = 7; go("R3");
      src0_reg = 3; go("R4");
      ren_en = 1; ren_dst = 3; ren_rob = 9; go("R4");
      // R5: commit of stale slot keeps newer mapping
      src0_reg = 3; commit_en = 1; commit_rob = 7; go("R5");
      src0_reg = 3; commit_en = 1; commit_rob = 9; go("R5");
      src0_reg = 3; go("R5");
      // R5: rename and matching commit on same row
      ren_en = 1; ren_dst = 2; ren_rob = 4; go("R5");
      src0_reg = 2; ren_en = 1; ren_dst = 2; ren_rob = 5; commit_en = 1; commit_rob = 4; go("R5");
      src0_reg = 2; go("R5");
      // R6: snapshot captures this cycle's rename
      ren_en = 1; ren_dst = 4; ren_rob = 11; ckpt_req = 1; go("R6");
      ren_en = 1; ren_dst = 4; ren_rob = 12; src0_reg = 4; go("R6");
      restore_en = 1; restore_slot = 0; ren_en = 1; ren_dst = 4; ren_rob = 30; go("R9");
      src0_reg = 4; go("R9");
      // R7: snapshot scrubbed by commit
      ren_en = 1; ren_dst = 5; ren_rob = 13; ckpt_req = 1; go("R7");
      commit_en = 1; commit_rob = 13; go("R7");
      restore_en = 1; restore_slot = 0; go("R7");
      src0_reg = 5; go("R7");
      // R8: full pool stalls rename
      flush = 1; go("R10");
      for (int k = 0; k < NCK; k++) begin ckpt_req = 1; ren_en = 1; ren_dst = 4'(k); ren_rob = 5'(16 + k); go("R6"); end
      ckpt_req = 1; ren_en = 1; ren_dst = 6; ren_rob = 20; src0_reg = 6; go("R8");
      src0_reg = 6; go("R8");
      // R9: restore middle slot frees later ones
      restore_en = 1; restore_slot = 2'((rd + 1) % NCK); go("R9");
      src0_reg = 1; src1_reg = 2; go("R9");
      // R11: release beyond empty has no effect
      for (int k = 0; k < 3; k++) begin ckpt_release = 1; go("R11"); end
      ckpt_req = 1; go("R11");
      go("R11");
      // R10: flush clears all
      ren_en = 1; ren_dst = 9; ren_rob = 3; go("R10");
      flush = 1; ckpt_req = 1; ren_en = 1; ren_dst = 9; ren_rob = 8; go("R10");
      src0_reg = 9; src1_reg = 1; go("R10");
      // R2: seeded random traffic
      for (int n = 0; n < 4000; n++) begin
         src0_reg = 4'($urandom_range(0, NREG-1));
         src1_reg = 4'($urandom_range(0, NREG-1));
         ren_en = ($urandom_range(0, 1) == 1);
         ren_dst = 4'($urandom_range(0, NREG-1));
         ren_rob = 5'($urandom_range(0, 31));
         commit_en = ($urandom_range(0, 1) == 1);
         commit_rob = ($urandom_range(0, 2) == 0) ? 5'($urandom_range(0, 31))
                                                   : 5'(mi[$urandom_range(0, NREG-1)]);
         ckpt_req = ($urandom_range(0, 3) == 0);
         ckpt_release = ($urandom_range(0, 5) == 0);
         if (cnt > 0 && $urandom_range(0, 11) == 0) begin
            restore_en = 1;
            restore_slot = 2'((rd + int'($urandom_range(0, cnt-1))) % NCK);
         end
         flush = ($urandom_range(0, 59) == 0);
         go("R2");
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule